// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block computes the address of the next instruction for a 32-bit machine whose instructions are one word long and word aligned. It takes the current program counter, the instruction word being executed, the outcome of the register equality comparison, and a mode bit. It returns the address to fetch next. Four cases are handled: straight-line flow, branch on equal, branch on not equal, and the direct jump.

Branch displacements count instructions, not bytes. The 16-bit signed immediate is therefore scaled by four and sign-extended before it is added. The mode bit selects the base of that addition. With the bit low, the base is the address after the branch, which matches a pipelined machine with a delay slot. With the bit high, the base is the branch's own address, which matches an instruction-set simulator that has no delay slot.

The jump target keeps the top four bits of the current PC. The 26-bit index from the instruction is placed below them, and the result is padded with two zero bits. The unit holds no state. The equality comparator, register-indirect jumps and exception vectors all live outside it.

The unit has no data stream, so there is no valid/ready handshake. Every pin is a plain level signal. The output follows the inputs in the same cycle.

Top module: `next_pc_unit`

## Requirements
- R1: The opcode is decoded from instruction bits 31:26. 6'b000100 is branch-on-equal, 6'b000101 is branch-on-not-equal, and 6'b000010 is the direct jump.
- R2: The branch displacement is instruction bits 15:0, taken as two's complement, shifted left by two and sign-extended to 32 bits. Its range is -131072 to +131068 bytes.
- R3: With `sim_mode_i` low, a taken branch gives `pc_i + 4 + displacement`.
- R4: With `sim_mode_i` high, a taken branch gives `pc_i + displacement`.
- R5: Branch-on-equal is taken when `regs_equal_i` is 1. Branch-on-not-equal is taken when `regs_equal_i` is 0.
- R6: A branch that is not taken gives `pc_i + 4` in either mode.
- R7: The jump gives {`pc_i[31:28]`, `instr_i[25:0]`, 2'b00}. Neither `regs_equal_i` nor `sim_mode_i` has any effect on it.
- R8: Any other opcode gives `pc_i + 4`. Neither `regs_equal_i` nor `sim_mode_i` has any effect on it.
- R9: All additions are modulo 2^32. For example, sequential flow from 0xFFFFFFFC gives 0x00000000.
- R10: The unit is purely combinational. `next_pc_o` reflects the current inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| regs_equal_i | input | 1 | 1 when the two compared registers are equal |
| sim_mode_i | input | 1 | 0: branch base is PC+4; 1: branch base is PC |
| next_pc_o | output | 32 | Address of the next instruction |

## Verification
The unit holds no registers, so a defect appears at `next_pc_o` in the same cycle as the instruction that exposes it. Such a defect is a wrong flow class from the decoder, a base chosen for the wrong mode, or a displacement extended from the wrong bit. Swapped branch polarity shows up as taken and not-taken results trading places for one equality value. Sign-extension errors only appear with an immediate whose top bit is set, and zero-padding errors only appear with one whose top bit is clear. For that reason the vectors include 0x7FFF, 0x8000 and 0xFFFF. Jump region errors only appear with a nonzero upper nibble of the PC, so all sixteen values are swept.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_BEQ = 6'b000100;
  localparam logic [OP_W-1:0] OPC_BNE = 6'b000101;
  localparam logic [OP_W-1:0] OPC_JMP = 6'b000010;

  typedef enum logic [1:0] {
    FLOW_SEQ    = 2'd0,
    FLOW_BRANCH = 2'd1,
    FLOW_JUMP   = 2'd2
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  input  logic            regs_equal_i,
  output flow_e           flow_o
);
  always_comb begin
    flow_o = FLOW_SEQ;
    unique case (opcode_i)
      OPC_BEQ: flow_o = regs_equal_i ? FLOW_BRANCH : FLOW_SEQ;
      OPC_BNE: flow_o = regs_equal_i ? FLOW_SEQ : FLOW_BRANCH;
      OPC_JMP: flow_o = FLOW_JUMP;
      default: flow_o = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_branch_target.sv
module npc_branch_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int ALIGN = 2
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sim_mode_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int EXT_W = XLEN - IMM_W - ALIGN;
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN);

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] base;

  assign disp     = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN{1'b0}}};
  assign base     = sim_mode_i ? pc_i : pc_i + STEP;
  assign target_o = base + disp;
endmodule

// File: rtl/npc_jump_target.sv
module npc_jump_target #(
  parameter int XLEN   = 32,
  parameter int JIDX_W = 26,
  parameter int ALIGN  = 2
) (
  input  logic [XLEN-JIDX_W-ALIGN-1:0] region_i,
  input  logic [JIDX_W-1:0]            index_i,
  output logic [XLEN-1:0]              target_o
);
  assign target_o = {region_i, index_i, {ALIGN{1'b0}}};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ALIGN = 2
) (
  input  flow_e           flow_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] branch_target_i,
  input  logic [XLEN-1:0] jump_target_i,
  output logic [XLEN-1:0] next_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN);

  always_comb begin
    unique case (flow_i)
      FLOW_BRANCH: next_pc_o = branch_target_i;
      FLOW_JUMP:   next_pc_o = jump_target_i;
      default:     next_pc_o = pc_i + STEP;
    endcase
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26,
  parameter int ALIGN  = 2
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic            regs_equal_i,
  input  logic            sim_mode_i,
  output logic [XLEN-1:0] next_pc_o
);
  localparam int REGION_W = XLEN - JIDX_W - ALIGN;

  flow_e           flow;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;

  npc_decode u_decode (
    .opcode_i     (instr_i[XLEN-1 -: OP_W]),
    .regs_equal_i (regs_equal_i),
    .flow_o       (flow)
  );

  npc_branch_target #(.XLEN(XLEN), .IMM_W(IMM_W), .ALIGN(ALIGN)) u_branch (
    .pc_i       (pc_i),
    .imm_i      (instr_i[IMM_W-1:0]),
    .sim_mode_i (sim_mode_i),
    .target_o   (br_target)
  );

  npc_jump_target #(.XLEN(XLEN), .JIDX_W(JIDX_W), .ALIGN(ALIGN)) u_jump (
    .region_i (pc_i[XLEN-1 -: REGION_W]),
    .index_i  (instr_i[JIDX_W-1:0]),
    .target_o (jmp_target)
  );

  npc_select #(.XLEN(XLEN), .ALIGN(ALIGN)) u_select (
    .flow_i          (flow),
    .pc_i            (pc_i),
    .branch_target_i (br_target),
    .jump_target_i   (jmp_target),
    .next_pc_o       (next_pc_o)
  );
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic            regs_equal_i,
  input logic            sim_mode_i,
  input logic [XLEN-1:0] next_pc_o
);
  localparam int REGION_W = XLEN - JIDX_W - 2;

  logic [5:0]      op;
  logic            is_br;
  logic            taken;
  logic [XLEN-1:0] disp;

  assign op    = instr_i[XLEN-1 -: 6];
  assign is_br = (op == 6'b000100) || (op == 6'b000101);
  assign taken = (op == 6'b000100) ? regs_equal_i : !regs_equal_i;
  assign disp  = XLEN'($signed(instr_i[IMM_W-1:0])) <<< 2;

  always_comb begin
    // R1, R8: opcodes outside the control-flow set fall through
    if (!is_br && op != 6'b000010)
      p_seq_r8: assert (next_pc_o == pc_i + XLEN'(4))
        else $error("sequential next pc wrong");
    // R3: taken branch with the delay-slot base
    if (is_br && taken && !sim_mode_i)
      p_br_hw_r3: assert (next_pc_o == pc_i + XLEN'(4) + disp)
        else $error("hardware-mode branch target wrong");
    // R4: taken branch with the branch's own address as base
    if (is_br && taken && sim_mode_i)
      p_br_sim_r4: assert (next_pc_o == pc_i + disp)
        else $error("simulator-mode branch target wrong");
    // R5, R6: not-taken branch
    if (is_br && !taken)
      p_not_taken_r6: assert (next_pc_o == pc_i + XLEN'(4))
        else $error("not-taken branch wrong");
    // R7: jump keeps the region and places the index
    if (op == 6'b000010)
      p_jump_r7: assert (next_pc_o[XLEN-1 -: REGION_W] == pc_i[XLEN-1 -: REGION_W]
                         && next_pc_o[JIDX_W+1:2] == instr_i[JIDX_W-1:0]
                         && next_pc_o[1:0] == 2'b00)
        else $error("jump target wrong");
    // R2: a word-aligned PC always leads to a word-aligned next PC
    if (pc_i[1:0] == 2'b00)
      p_aligned_r2: assert (next_pc_o[1:0] == 2'b00)
        else $error("next pc misaligned");
  end
endmodule

bind next_pc_unit next_pc_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_chk (
  .pc_i         (pc_i),
  .instr_i      (instr_i),
  .regs_equal_i (regs_equal_i),
  .sim_mode_i   (sim_mode_i),
  .next_pc_o    (next_pc_o)
);

// File: tb/next_pc_unit_tb.sv
module next_pc_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 14;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] instr;
    logic        eq;
    logic        sim;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // R1 R2 R3 R4 R5 R6 R7 R8 R9 covered by the table below
  localparam vec_t VECS [NVEC] = '{
    '{32'h00400024, 32'h15150003, 1'b0, 1'b1, 32'h00400030, 4'd4},  // R4 bne taken, sim
    '{32'h00400024, 32'h15150003, 1'b0, 1'b0, 32'h00400034, 4'd3},  // R3 bne taken, hw
    '{32'h00400024, 32'h15150003, 1'b1, 1'b1, 32'h00400028, 4'd6},  // R6 bne not taken
    '{32'h00400020, 32'h0810000B, 1'b0, 1'b1, 32'h0040002C, 4'd7},  // R7 jump
    '{32'hF0001000, 32'h0810000B, 1'b1, 1'b0, 32'hF040002C, 4'd7},  // R7 region kept
    '{32'h00001000, 32'h1000FFFF, 1'b1, 1'b0, 32'h00001000, 4'd2},  // R2 beq -1, hw
    '{32'h00001000, 32'h1000FFFF, 1'b1, 1'b1, 32'h00000FFC, 4'd2},  // R2 beq -1, sim
    '{32'h00001000, 32'h1000FFFF, 1'b0, 1'b1, 32'h00001004, 4'd5},  // R5 beq needs equal
    '{32'h00400000, 32'h012A4020, 1'b1, 1'b1, 32'h00400004, 4'd8},  // R8 alu op
    '{32'h10010000, 32'h8D2B0004, 1'b0, 1'b0, 32'h10010004, 4'd8},  // R8 load op
    '{32'hFFFFFFFC, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 4'd9},  // R9 wrap
    '{32'h00400000, 32'h10007FFF, 1'b1, 1'b0, 32'h00420000, 4'd2},  // R2 max positive
    '{32'h00420000, 32'h14008000, 1'b0, 1'b1, 32'h00400000, 4'd2},  // R2 most negative
    '{32'h00420000, 32'h14008000, 1'b1, 1'b1, 32'h00420004, 4'd5}   // R5 bne equal
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic [31:0] instr_i = '0;
  logic        regs_equal_i = 1'b0;
  logic        sim_mode_i = 1'b0;
  logic [31:0] next_pc_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  next_pc_unit dut_i (
    .pc_i         (pc_i),
    .instr_i      (instr_i),
    .regs_equal_i (regs_equal_i),
    .sim_mode_i   (sim_mode_i),
    .next_pc_o    (next_pc_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] pc, input logic [31:0] ins,
                       input logic eq, input logic sim);
    @(posedge clk);
    pc_i         = pc;
    instr_i      = ins;
    regs_equal_i = eq;
    sim_mode_i   = sim;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R8 initial state: all-zero inputs give the sequential address 4
    @(negedge clk);
    check("R8 initial zero inputs", next_pc_o, 32'h00000004);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].pc, VECS[i].instr, VECS[i].eq, VECS[i].sim);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), next_pc_o, VECS[i].exp);
    end

    // R7: every region nibble, with mode and equality toggled to show no effect
    for (int k = 0; k < 16; k++) begin
      apply({k[3:0], 28'h0000010}, 32'h0BFFFFFF, k[0], k[1]);
      check("R7 region sweep", next_pc_o, {k[3:0], 28'hFFFFFFC});
    end

    // R8: non-control opcode ignores both control inputs
    for (int m = 0; m < 4; m++) begin
      apply(32'h00400100, 32'h3C017F40, m[0], m[1]);
      check("R8 mode and equal ignored", next_pc_o, 32'h00400104);
    end

    // R10: output follows an input change with no clock edge
    @(negedge clk);
    pc_i    = 32'h00000200;
    instr_i = 32'h00000000;
    #1;
    check("R10 same-cycle response", next_pc_o, 32'h00000204);
    instr_i = 32'h08000040;
    #1;
    check("R10 same-cycle jump", next_pc_o, 32'h00000100);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule